// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block receives characters from an asynchronous serial line. It oversamples the receive line at sixteen times the bit rate and confirms a start bit at the middle of that bit. Each data bit and the stop bit are then decided by a vote over three samples. The data bits are collected into a shift register. A finished character moves into a two-entry holding queue, and a host drains the queue one word at a time with a read strobe. The host sees the oldest unread word, its ninth bit and its framing-error flag on the outputs at all times.

Characters carry 8 data bits, or 9 when nine-bit mode is on. In address-filter mode, nine-bit characters whose ninth bit is clear are dropped. A third character that finishes while both queue entries are unread raises a sticky overrun flag and is lost. The only way to clear overrun is to drop the receive enable and raise it again, which also returns the receiver to idle.

Top module: `uart_rx_buffered`

## Requirements
- R1: A frame is a low start bit, data bits sent least significant first, then a high stop bit. The receiver presents the received byte on `rd_data` with bit 0 equal to the first data bit after the start bit.
- R2: When `nine_bit`=1, a ninth data bit follows bit 7 and appears on `rd_bit8`. When `nine_bit`=0, `rd_bit8` reads 0.
- R3: The queue holds two unread words and gives them out in arrival order. While it is full, a further frame is still shifted in.
- R4: A frame that completes while both entries are unread sets `overrun` and is discarded. The two stored words stay unchanged.
- R5: `data_avail` is 1 while at least one unread word is queued. It drops to 0 once reads through `rd_pop` have emptied the queue.
- R6: `rx_idle` is 1 while no frame is in progress. It is 0 from a confirmed start-bit edge until the stop bit has been decided.
- R7: `rd_ferr` belongs to the word shown at the head of the queue. It is 1 when that word's stop bit was decided low.
- R8: While `rx_en`=0, the line is ignored: `rx_idle` stays 1 and no word enters the queue.
- R9: The oversampling tick repeats every D+1 clocks, so one bit lasts 16×(D+1) clocks. D = {`baud_hi`,`baud_lo`} when `div_wide`=1. D = `baud_lo` when `div_wide`=0, and `baud_hi` then has no effect.
- R10: While `overrun` is 1, no word enters the queue. It clears only when `rx_en` goes low, after which a frame received with `rx_en`=1 is queued again.
- R11: A low pulse on the line that is back high at the middle of the start bit does not start a frame. Nothing is queued from it.
- R12: With `addr_mode`=1 and `nine_bit`=1, only words whose ninth bit is 1 enter the queue. Other words are dropped without setting any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Continuous receive enable; low also clears overrun |
| nine_bit | input | 1 | Nine data bits per frame |
| addr_mode | input | 1 | Keep only nine-bit words whose ninth bit is 1 |
| div_wide | input | 1 | Use the full 16-bit divisor instead of the low byte only |
| baud_hi | input | 8 | Divisor high byte |
| baud_lo | input | 8 | Divisor low byte |
| rd_pop | input | 1 | Remove the head word from the queue |
| rd_data | output | 8 | Head word data |
| rd_bit8 | output | 1 | Head word ninth bit |
| rd_ferr | output | 1 | Head word framing error |
| data_avail | output | 1 | Queue holds at least one unread word |
| rx_idle | output | 1 | No frame in progress |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sends every 8-bit value, and a sweep of nine-bit values with both ninth-bit levels, and checks bit order and the ninth bit. A design that shifted MSB first or dropped the ninth bit fails on nearly every word. It fills the queue and sends a third frame, then checks that the first two words come out in order, that the third is gone and that later frames stay blocked until the enable toggles. A design that overwrote the tail or cleared overrun on a read fails here. Further cases are a short start glitch, a low stop bit, address filtering, gated reception, and a high divisor byte that must be ignored in narrow mode. A receiver that started on noise, lost the per-word error flag, kept unaddressed words or used the wrong bit period would report wrong words or flags.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR      = 16;
    localparam int DATA_W   = 8;
    localparam int FRAME_W  = DATA_W + 1;
    localparam int TCNT_W   = $clog2(OSR);
    localparam int BIDX_W   = $clog2(FRAME_W);
    localparam int DIV_W    = 16;

    // Tick positions inside one bit, counted from the bit's first tick
    localparam logic [TCNT_W-1:0] MID_A = TCNT_W'(OSR/2 - 1);
    localparam logic [TCNT_W-1:0] MID_B = TCNT_W'(OSR/2);
    localparam logic [TCNT_W-1:0] MID_C = TCNT_W'(OSR/2 + 1);
    localparam logic [TCNT_W-1:0] LAST_T = TCNT_W'(OSR - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit8;
        logic              ferr;
    } rx_word_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wide,
    input  logic [7:0]       baud_hi,
    input  logic [7:0]       baud_lo,
    output logic             tick
);
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] cnt;

    always_comb begin
        if (div_wide)
            divisor = {baud_hi, baud_lo};
        else
            divisor = {8'h00, baud_lo};
    end

    assign tick = (cnt >= divisor);

    always_ff @(posedge clk) begin
        if (rst || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && divisor != '0 && $stable(divisor)) |=> !tick) else $error("tick spacing"); // R9

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic rx_s
);
    logic [SYNC_STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= 1'b1;
                else if (g == 0)
                    chain[g] <= rxd;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign rx_s = chain[SYNC_STAGES-1];

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     tick,
    input  logic     rx_s,
    input  logic     nine_bit,
    output logic     done,
    output rx_word_t word,
    output logic     busy
);
    rx_state_t           state;
    logic [TCNT_W-1:0]   tcnt;
    logic [BIDX_W-1:0]   bidx;
    logic                smp_a, smp_b;
    logic [FRAME_W-1:0]  shreg;
    logic [BIDX_W-1:0]   last_idx;
    logic                decided;

    assign last_idx = nine_bit ? BIDX_W'(FRAME_W-1) : BIDX_W'(DATA_W-1);
    assign decided  = vote3(smp_a, smp_b, rx_s);
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= ST_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            smp_a <= 1'b1;
            smp_b <= 1'b1;
            shreg <= '0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            state <= ST_START;
                            tcnt  <= TCNT_W'(1);
                        end
                    end
                    ST_START: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == MID_A && rx_s) begin
                            state <= ST_IDLE;
                            tcnt  <= '0;
                        end else if (tcnt == LAST_T) begin
                            state <= ST_DATA;
                            tcnt  <= '0;
                            bidx  <= '0;
                        end
                    end
                    ST_DATA: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == MID_A) smp_a <= rx_s;
                        if (tcnt == MID_B) smp_b <= rx_s;
                        if (tcnt == MID_C) shreg[bidx] <= decided;
                        if (tcnt == LAST_T) begin
                            tcnt <= '0;
                            if (bidx == last_idx)
                                state <= ST_STOP;
                            else
                                bidx <= bidx + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == MID_A) smp_a <= rx_s;
                        if (tcnt == MID_B) smp_b <= rx_s;
                        if (tcnt == MID_C) begin
                            state     <= ST_IDLE;
                            tcnt      <= '0;
                            done      <= 1'b1;
                            word.data <= shreg[DATA_W-1:0];
                            word.bit8 <= nine_bit & shreg[FRAME_W-1];
                            word.ferr <= ~decided;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_START_ON_LOW: assert property (@(posedge clk) disable iff (rst || clr)
        $rose(busy) |-> $past(!rx_s)) else $error("frame began on high line"); // R6

    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst || clr)
        done |-> !busy) else $error("done while busy"); // R6

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
)(
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_word_t push_word,
    input  logic     pop,
    output rx_word_t head,
    output logic     full,
    output logic     nonempty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_word_t           mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [CNT_W-1:0]   count;
    logic               do_push, do_pop;

    assign full     = (count == CNT_W'(DEPTH));
    assign nonempty = (count != '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;
    assign head     = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= push_word;
                wptr      <= bump(wptr);
            end
            if (do_pop) rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)) else $error("fifo over depth"); // R3

    AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(1) && pop && !push) |=> !nonempty) else $error("fifo not emptied"); // R5

endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered
    import uart_rx_pkg::*;
#(
    parameter int BUF_DEPTH = 2
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       addr_mode,
    input  logic       div_wide,
    input  logic [7:0] baud_hi,
    input  logic [7:0] baud_lo,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_bit8,
    output logic       rd_ferr,
    output logic       data_avail,
    output logic       rx_idle,
    output logic       overrun
);
    logic     tick, rx_s, done, busy, fifo_full, fifo_ne;
    logic     accept, push;
    rx_word_t word, head;

    uart_rx_baud u_baud (
        .clk(clk), .rst(rst), .div_wide(div_wide),
        .baud_hi(baud_hi), .baud_lo(baud_lo), .tick(tick)
    );

    uart_rx_sampler #(.SYNC_STAGES(2)) u_samp (
        .clk(clk), .rst(rst), .rxd(rxd), .rx_s(rx_s)
    );

    uart_rx_framer u_frm (
        .clk(clk), .rst(rst), .clr(!rx_en), .tick(tick), .rx_s(rx_s),
        .nine_bit(nine_bit), .done(done), .word(word), .busy(busy)
    );

    // Address filter, then overrun gate
    assign accept = done && !overrun && (!(addr_mode && nine_bit) || word.bit8);
    assign push   = accept && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst || !rx_en)
            overrun <= 1'b0;
        else if (accept && fifo_full)
            overrun <= 1'b1;
    end

    uart_rx_fifo #(.DEPTH(BUF_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_word(word), .pop(rd_pop),
        .head(head), .full(fifo_full), .nonempty(fifo_ne)
    );

    assign rd_data    = head.data;
    assign rd_bit8    = head.bit8;
    assign rd_ferr    = head.ferr;
    assign data_avail = fifo_ne;
    assign rx_idle    = !busy;

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(fifo_full)) else $error("overrun without full queue"); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && rx_en) |=> overrun) else $error("overrun cleared while enabled"); // R10

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (rx_idle || rx_en)) else $error("busy while disabled"); // R8

endmodule

// File: tb/tb_uart_rx_buffered.sv
module tb_uart_rx_buffered;

    logic       clk = 1'b0;
    logic       rst, rxd, rx_en, nine_bit, addr_mode, div_wide, rd_pop;
    logic [7:0] baud_hi, baud_lo;
    logic [7:0] rd_data;
    logic       rd_bit8, rd_ferr, data_avail, rx_idle, overrun;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;
    logic idle_mid;

    always #10 clk = ~clk;   // 50 MHz

    uart_rx_buffered dut (
        .clk(clk), .rst(rst), .rxd(rxd), .rx_en(rx_en), .nine_bit(nine_bit),
        .addr_mode(addr_mode), .div_wide(div_wide), .baud_hi(baud_hi),
        .baud_lo(baud_lo), .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit8(rd_bit8),
        .rd_ferr(rd_ferr), .data_avail(data_avail), .rx_idle(rx_idle),
        .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // Drive one frame: start, nb data bits LSB first, stop at stopv, then one idle bit
    task automatic send(input logic [8:0] w, input int nb, input logic stopv, input int bclk);
        rxd = 1'b0;
        repeat (bclk) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = w[i];
            repeat (bclk / 2) @(negedge clk);
            if (i == 3) idle_mid = rx_idle;
            repeat (bclk - bclk / 2) @(negedge clk);
        end
        rxd = stopv;
        repeat (bclk) @(negedge clk);
        rxd = 1'b1;
        repeat (bclk) @(negedge clk);
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; rx_en = 1'b1; nine_bit = 1'b0; addr_mode = 1'b0;
        div_wide = 1'b0; baud_hi = 8'h00; baud_lo = 8'h00; rd_pop = 1'b0;
        idle_mid = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        eq("R5 reset data_avail", data_avail, 0);
        eq("R6 reset rx_idle", rx_idle, 1);
        eq("R4 reset overrun", overrun, 0);
        eq("R1 reset rd_data", rd_data, 0);

        // R1/R2/R5/R6: every 8-bit value, divisor 0 (16 clocks per bit)
        for (int v = 0; v < 256; v++) begin
            send({1'b1, 8'(v)}, 8, 1'b1, 16);
            eq("R6 idle low mid-frame", idle_mid, 0);
            eq("R6 idle after frame", rx_idle, 1);
            eq("R5 avail after frame", data_avail, 1);
            eq("R1 byte LSB first", rd_data, v);
            eq("R2 bit8 zero in 8-bit mode", rd_bit8, 0);
            eq("R7 ferr clear", rd_ferr, 0);
            pop();
            eq("R5 avail after drain", data_avail, 0);
        end

        // R2: nine-bit sweep, ninth bit alternating
        nine_bit = 1'b1;
        for (int v = 0; v < 64; v++) begin
            logic [8:0] w;
            w = {v[0], 8'((v * 37 + 11) & 255)};
            send(w, 9, 1'b1, 16);
            eq("R2 nine-bit data", rd_data, int'(w[7:0]));
            eq("R2 ninth bit", rd_bit8, int'(w[8]));
            pop();
        end

        // R12: address filter
        addr_mode = 1'b1;
        send(9'h0A5, 9, 1'b1, 16);
        eq("R12 unaddressed word dropped", data_avail, 0);
        eq("R12 no overrun from drop", overrun, 0);
        send(9'h13C, 9, 1'b1, 16);
        eq("R12 addressed word kept", data_avail, 1);
        eq("R12 addressed data", rd_data, 8'h3C);
        eq("R12 addressed bit8", rd_bit8, 1);
        pop();
        addr_mode = 1'b0;
        nine_bit  = 1'b0;

        // R7: framing error attached to its own word
        send(9'h055, 8, 1'b0, 16);
        repeat (32) @(negedge clk);
        send(9'h0AA, 8, 1'b1, 16);
        eq("R7 head word data", rd_data, 8'h55);
        eq("R7 ferr set for low stop", rd_ferr, 1);
        pop();
        eq("R7 second word data", rd_data, 8'hAA);
        eq("R7 ferr clear on next word", rd_ferr, 0);
        pop();

        // R11: short start glitch
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        eq("R11 glitch leaves idle", rx_idle, 1);
        eq("R11 glitch queues nothing", data_avail, 0);

        // R3/R4/R10: fill, overrun, blocked, clear
        send(9'h011, 8, 1'b1, 16);
        send(9'h022, 8, 1'b1, 16);
        eq("R4 no overrun at two words", overrun, 0);
        send(9'h033, 8, 1'b1, 16);
        eq("R4 overrun on third word", overrun, 1);
        eq("R3 first word kept", rd_data, 8'h11);
        pop();
        eq("R3 second word in order", rd_data, 8'h22);
        pop();
        eq("R4 third word discarded", data_avail, 0);
        send(9'h044, 8, 1'b1, 16);
        eq("R10 blocked while overrun", data_avail, 0);
        eq("R10 overrun sticky", overrun, 1);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        @(negedge clk);
        eq("R10 overrun cleared by enable toggle", overrun, 0);
        send(9'h066, 8, 1'b1, 16);
        eq("R10 reception resumes", data_avail, 1);
        eq("R10 resumed data", rd_data, 8'h66);
        pop();

        // R8: disabled receiver ignores the line
        rx_en = 1'b0;
        send(9'h0C3, 8, 1'b1, 16);
        eq("R8 idle while disabled", idle_mid, 1);
        eq("R8 nothing queued while disabled", data_avail, 0);
        rx_en = 1'b1;
        @(negedge clk);

        // R9: narrow mode ignores high byte; wide divisor of 2 gives 48 clocks per bit
        baud_hi = 8'h12;
        send(9'h09E, 8, 1'b1, 16);
        eq("R9 high byte ignored in narrow mode", rd_data, 8'h9E);
        pop();
        baud_hi = 8'h00; baud_lo = 8'h02; div_wide = 1'b1;
        repeat (8) @(negedge clk);
        send(9'h0D7, 8, 1'b1, 48);
        eq("R9 wide divisor data", rd_data, 8'hD7);
        eq("R9 wide divisor avail", data_avail, 1);
        pop();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule